// File: doc/BRIEF.md
# Duty-Cycled Wake-Up Controller with Pulse-Width Qualification

This block decides when an on-off keyed receiver is worth keeping powered. It sits between the sliced data from the demodulator and the logic that consumes it. When automatic polling is off, the receiver stays powered and the data goes straight through a synchronizer. When polling is on, the block turns the receiver off for a programmed interval. It then powers it up and measures every high and low run on the data line. If the line looks like a real transmission, the block locks into continuous reception. If it looks like noise, the block goes back to sleep.

A run counts as a good symbol when it lasts longer than a qualification window. The window is picked by a 3-bit code and then halved once for each step of a 2-bit bandwidth code. A configurable number of good symbols in a row releases the data output. Four short runs in a row end the poll. Once locked, the block stays awake until software drops the enable and raises it again. All widths and intervals are counted in microsecond ticks supplied from outside.

Top module: `rx_wake_poll`

## Requirements
- R1: Out of reset, and whenever `cfg_poll_en` is 0, `rx_pwr_en` is 1 and `link_up` is 0. `data_out` then equals `data_in` delayed by exactly two clock cycles.
- R2: A 0-to-1 change of `cfg_poll_en` starts a sleep interval with `rx_pwr_en` at 0. The interval lasts SLEEP_BASE_TICKS × 2^`cfg_sleep_code` ticks (code 0 = 10 ms at the default base, code 7 = 1280 ms), after which polling starts with `rx_pwr_en` at 1.
- R3: While sleeping or polling, `data_out` is 0 whatever `data_in` does.
- R4: The window in ticks is W(code) >> `cfg_bw_code`, where W for `cfg_win_code` 0..7 is 570, 532, 494, 457, 419, 381, 343, 305. A run strictly longer than the window is valid. A run equal to or shorter than the window is bad.
- R5: `cfg_need_code` 1, 2 and 3 require 4, 8 and 16 valid runs in a row. The poll locks on the edge that completes the last of them, and not before.
- R6: Four bad runs in a row during polling return the block to sleep.
- R7: A bad run clears the count of consecutive valid runs.
- R8: A valid run clears the count of consecutive bad runs.
- R9: After lock, `link_up` is 1, `rx_pwr_en` stays 1 and `data_out` follows the synchronized data, however long the line is idle. Only a 1-0-1 sequence on `cfg_poll_en` starts a new sleep.
- R10: With `cfg_need_code` = 0, the block locks on the cycle after polling starts.
- R11: The first edge seen in a poll only starts a measurement. The time from poll start to that edge is never classified.
- R12: Run widths saturate at the counter maximum (1023 ticks at the default width), so a run longer than that still counts as valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond; all widths and intervals are counted in these |
| data_in | input | 1 | Raw sliced data from the demodulator, asynchronous |
| cfg_poll_en | input | 1 | 1 enables sleep/poll duty cycling |
| cfg_sleep_code | input | 3 | Sleep interval select |
| cfg_win_code | input | 3 | Qualification window select |
| cfg_need_code | input | 2 | Number of consecutive valid runs needed to lock |
| cfg_bw_code | input | 2 | Bandwidth step; each step halves the window |
| rx_pwr_en | output | 1 | 1 powers the receiver front end |
| data_out | output | 1 | Synchronized data, forced to 0 while sleeping or polling |
| link_up | output | 1 | 1 once polling has locked into continuous reception |

## Verification
A wrong run counter or window value shows up as `link_up` rising one edge too early or too late, or as `rx_pwr_en` falling when it should not. Either is visible within a few cycles of the edge that ends the deciding run. A measurement that wraps instead of saturating, or that starts from the poll entry instead of the first edge, shifts the lock by one run. Sequences built to sit exactly one run from the decision expose it. Sleep timer faults show as a sleep length that is off by a factor of two or more, measured from the enable edge to the power rise.

// File: rtl/rxw_pkg.sv
// Shared types and lookup functions for the wake-up controller.
// Assumes window values are in microseconds and fit in 10 bits.
package rxw_pkg;

    typedef enum logic [1:0] {
        ST_BYPASS = 2'd0,
        ST_SLEEP  = 2'd1,
        ST_POLL   = 2'd2,
        ST_RECV   = 2'd3
    } rxw_state_t;

    // Window length at the lowest bandwidth step, indexed by window code.
    function automatic logic [9:0] window_base_us(input logic [2:0] code);
        logic [9:0] w;
        case (code)
            3'd0:    w = 10'd570;
            3'd1:    w = 10'd532;
            3'd2:    w = 10'd494;
            3'd3:    w = 10'd457;
            3'd4:    w = 10'd419;
            3'd5:    w = 10'd381;
            3'd6:    w = 10'd343;
            default: w = 10'd305;
        endcase
        return w;
    endfunction

    // Consecutive valid runs needed to lock, indexed by the count code.
    function automatic logic [4:0] valid_need(input logic [1:0] code);
        logic [4:0] n;
        case (code)
            2'd0:    n = 5'd0;
            2'd1:    n = 5'd4;
            2'd2:    n = 5'd8;
            default: n = 5'd16;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rxw_sync_edge.sv
// Multi-flop synchronizer for the asynchronous sliced data, plus edge detect.
// Assumes SYNC_STAGES >= 1; latency from din to dout is SYNC_STAGES cycles.
module rxw_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout,
    output logic edge_seen
);

    logic [SYNC_STAGES-1:0] stg;
    logic                   prev_q;

    // Shift the raw input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    // Keep the previous synchronized value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= stg[SYNC_STAGES-1];
        end
    end

    assign dout      = stg[SYNC_STAGES-1];
    assign edge_seen = stg[SYNC_STAGES-1] ^ prev_q;

endmodule

// File: rtl/rxw_pulse_meter.sv
// Measures the tick count between consecutive data edges.
// Counter saturates at its maximum. A measurement is reported only when
// an earlier edge in the same active period armed the meter.
module rxw_pulse_meter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             edge_seen,
    input  logic             active,
    output logic             meas_stb,
    output logic [CNT_W-1:0] meas_width
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;

    // Count ticks since the last edge, restarting at each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (edge_seen) begin
            cnt_q <= CNT_W'(tick);
        end else if (tick && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Arm on the first edge of an active period; disarm when inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (!active) begin
            armed_q <= 1'b0;
        end else if (edge_seen) begin
            armed_q <= 1'b1;
        end
    end

    assign meas_stb   = edge_seen && armed_q && active;
    assign meas_width = cnt_q;

endmodule

// File: rtl/rxw_bit_judge.sv
// Classifies measured runs against the window and tracks run streaks.
// Signals lock when the valid streak reaches the needed count and give-up
// when the bad streak reaches BAD_LIMIT. Assumes need > 0 when used.
module rxw_bit_judge #(
    parameter int CNT_W     = 10,
    parameter int BAD_LIMIT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             meas_stb,
    input  logic [CNT_W-1:0] meas_width,
    input  logic [2:0]       win_code,
    input  logic [1:0]       bw_code,
    input  logic [4:0]       need,
    output logic             lock_hit,
    output logic             give_up
);

    import rxw_pkg::*;

    localparam int BAD_W = $clog2(BAD_LIMIT + 1);

    logic [9:0]       win_us;
    logic             is_long;
    logic [4:0]       vrun_q;
    logic [4:0]       vrun_nx;
    logic [BAD_W-1:0] brun_q;

    // Window for the selected code, halved once per bandwidth step.
    always_comb begin
        win_us  = window_base_us(win_code) >> bw_code;
        is_long = 32'(meas_width) > 32'(win_us);
        vrun_nx = vrun_q + 5'd1;
    end

    // Update the consecutive valid and bad streak counters.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            vrun_q <= '0;
            brun_q <= '0;
        end else if (meas_stb) begin
            if (is_long) begin
                vrun_q <= vrun_nx;
                brun_q <= '0;
            end else begin
                vrun_q <= '0;
                brun_q <= brun_q + 1'b1;
            end
        end
    end

    assign lock_hit = meas_stb && is_long && (vrun_nx == need);
    assign give_up  = meas_stb && !is_long &&
                      (brun_q == BAD_W'(BAD_LIMIT - 1));

endmodule

// File: rtl/rxw_sleep_timer.sv
// Counts ticks while sleeping and flags expiry of the selected interval.
// Interval is SLEEP_BASE_TICKS shifted left by the 3-bit code.
module rxw_sleep_timer #(
    parameter int SLEEP_BASE_TICKS = 10000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       run,
    input  logic [2:0] code,
    output logic       expire
);

    localparam int SLEEP_W = $clog2(SLEEP_BASE_TICKS * 128 + 1);

    logic [SLEEP_W-1:0] len;
    logic [SLEEP_W-1:0] cnt_q;

    // Interval length for the selected code.
    always_comb begin
        len = SLEEP_W'(SLEEP_BASE_TICKS) << code;
    end

    assign expire = run && (cnt_q == len);

    // Advance on ticks while running; clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (tick && !expire) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/rx_wake_poll.sv
// Top of the duty-cycled wake-up controller. Sequences bypass, sleep,
// poll and locked-receive states; gates power and data accordingly.
// Assumes us_tick is a single-cycle pulse in the clk domain.
module rx_wake_poll #(
    parameter int SLEEP_BASE_TICKS = 10000,
    parameter int CNT_W            = 10,
    parameter int SYNC_STAGES      = 2,
    parameter int BAD_LIMIT        = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       us_tick,
    input  logic       data_in,
    input  logic       cfg_poll_en,
    input  logic [2:0] cfg_sleep_code,
    input  logic [2:0] cfg_win_code,
    input  logic [1:0] cfg_need_code,
    input  logic [1:0] cfg_bw_code,
    output logic       rx_pwr_en,
    output logic       data_out,
    output logic       link_up
);

    import rxw_pkg::*;

    rxw_state_t       state_q, state_nx;
    logic             en_q;
    logic             data_s;
    logic             edge_seen;
    logic             polling;
    logic             meas_stb;
    logic [CNT_W-1:0] meas_width;
    logic             lock_hit;
    logic             give_up;
    logic             sleep_done;
    logic [4:0]       need;

    assign polling = (state_q == ST_POLL);
    assign need    = valid_need(cfg_need_code);

    rxw_sync_edge #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (data_in),
        .dout      (data_s),
        .edge_seen (edge_seen)
    );

    rxw_pulse_meter #(
        .CNT_W(CNT_W)
    ) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (us_tick),
        .edge_seen  (edge_seen),
        .active     (polling),
        .meas_stb   (meas_stb),
        .meas_width (meas_width)
    );

    rxw_bit_judge #(
        .CNT_W    (CNT_W),
        .BAD_LIMIT(BAD_LIMIT)
    ) u_judge (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (!polling),
        .meas_stb   (meas_stb),
        .meas_width (meas_width),
        .win_code   (cfg_win_code),
        .bw_code    (cfg_bw_code),
        .need       (need),
        .lock_hit   (lock_hit),
        .give_up    (give_up)
    );

    rxw_sleep_timer #(
        .SLEEP_BASE_TICKS(SLEEP_BASE_TICKS)
    ) u_sleep (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (us_tick),
        .run    (state_q == ST_SLEEP),
        .code   (cfg_sleep_code),
        .expire (sleep_done)
    );

    // Remember the enable so only a fresh rise starts a sleep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= cfg_poll_en;
        end
    end

    // Next-state selection for the duty-cycle sequencer.
    always_comb begin
        state_nx = state_q;
        case (state_q)
            ST_BYPASS: if (cfg_poll_en && !en_q) state_nx = ST_SLEEP;
            ST_SLEEP: begin
                if (!cfg_poll_en)    state_nx = ST_BYPASS;
                else if (sleep_done) state_nx = ST_POLL;
            end
            ST_POLL: begin
                if (!cfg_poll_en)                state_nx = ST_BYPASS;
                else if (need == 5'd0 || lock_hit) state_nx = ST_RECV;
                else if (give_up)                state_nx = ST_SLEEP;
            end
            default: if (!cfg_poll_en) state_nx = ST_BYPASS;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_BYPASS;
        end else begin
            state_q <= state_nx;
        end
    end

    assign rx_pwr_en = (state_q != ST_SLEEP);
    assign data_out  = data_s && ((state_q == ST_BYPASS) || (state_q == ST_RECV));
    assign link_up   = (state_q == ST_RECV);

endmodule

// File: rtl/rx_wake_poll_chk.sv
// Port-level temporal checks for the wake-up controller, bound to the top.
module rx_wake_poll_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_poll_en,
    input logic rx_pwr_en,
    input logic data_out,
    input logic link_up
);

    // Enable low in the previous cycle forces the powered bypass state.
    assert_bypass_powered_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cfg_poll_en) |-> (rx_pwr_en && !link_up));

    // Leaving sleep always enters polling or bypass, never locked receive.
    assert_wake_unlocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_pwr_en) |-> !link_up);

    // No data and no lock while the receiver is powered down.
    assert_sleep_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_pwr_en |-> (!data_out && !link_up));

    // Lock is reached only from a powered, enabled poll.
    assert_lock_from_poll_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up) |-> ($past(rx_pwr_en) && $past(cfg_poll_en)));

    // Falling into sleep needs polling to be enabled.
    assert_sleep_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_pwr_en) |-> $past(cfg_poll_en));

    // Lock persists as long as the enable stays high.
    assert_lock_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && cfg_poll_en) |=> link_up);

endmodule

bind rx_wake_poll rx_wake_poll_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_poll_en (cfg_poll_en),
    .rx_pwr_en   (rx_pwr_en),
    .data_out    (data_out),
    .link_up     (link_up)
);

// File: tb/rx_wake_poll_bench.sv
module rx_wake_poll_bench;

    localparam int SB = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       us_tick = 1'b1;
    logic       data_in = 1'b0;
    logic       cfg_poll_en = 1'b0;
    logic [2:0] cfg_sleep_code = 3'd0;
    logic [2:0] cfg_win_code = 3'd0;
    logic [1:0] cfg_need_code = 2'd0;
    logic [1:0] cfg_bw_code = 2'd0;
    logic       rx_pwr_en;
    logic       data_out;
    logic       link_up;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    rx_wake_poll #(.SLEEP_BASE_TICKS(SB)) u_rx_wake_poll (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .data_in(data_in),
        .cfg_poll_en(cfg_poll_en), .cfg_sleep_code(cfg_sleep_code),
        .cfg_win_code(cfg_win_code), .cfg_need_code(cfg_need_code),
        .cfg_bw_code(cfg_bw_code), .rx_pwr_en(rx_pwr_en),
        .data_out(data_out), .link_up(link_up)
    );

    always #5 clk = ~clk;

    function automatic int exp_window(input int code, input int bw);
        int b;
        case (code)
            0: b = 570; 1: b = 532; 2: b = 494; 3: b = 457;
            4: b = 419; 5: b = 381; 6: b = 343; default: b = 305;
        endcase
        return b >> bw;
    endfunction

    function automatic int exp_need(input int code);
        return (code == 0) ? 0 : (4 << (code - 1));
    endfunction

    function automatic int exp_sleep(input int code);
        return SB << code;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic toggle_hold(input int w);
        data_in = ~data_in;
        repeat (w) @(negedge clk);
    endtask

    // Set codes, raise the enable from low; return cycles spent asleep.
    task automatic arm(input int sc, input int wc, input int nc, input int bw, output int slept);
        cfg_poll_en = 1'b0;
        cfg_sleep_code = 3'(sc);
        cfg_win_code = 3'(wc);
        cfg_need_code = 2'(nc);
        cfg_bw_code = 2'(bw);
        repeat (3) @(negedge clk);
        cfg_poll_en = 1'b1;
        slept = 0;
        @(negedge clk);
        while (!rx_pwr_en && slept < 60000) begin
            slept++;
            @(negedge clk);
        end
    endtask

    task automatic wait_wake();
        int n = 0;
        while (!rx_pwr_en && n < 60000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int slept;
        int hist [0:63];
        void'($urandom(32'd20240611));

        // Reset state (R1)
        repeat (3) @(negedge clk);
        check(rx_pwr_en === 1'b1, "R1 reset pwr", int'(rx_pwr_en), 1);
        check(link_up === 1'b0, "R1 reset link", int'(link_up), 0);
        check(data_out === 1'b0, "R1 reset data", int'(data_out), 0);
        rst_n = 1'b1;

        // R1: pass-through with two-cycle latency
        for (int k = 0; k < 48; k++) begin
            if (k >= 2)
                check(data_out === hist[k-2][0], "R1 bypass data",
                      int'(data_out), hist[k-2]);
            hist[k] = int'($urandom % 2);
            data_in = hist[k][0];
            @(negedge clk);
        end
        check(rx_pwr_en && !link_up, "R1 bypass pwr/link", int'(rx_pwr_en), 1);

        // R2: sleep length, codes 1 and 0; R3 data quiet during sleep
        cfg_poll_en = 1'b0; cfg_sleep_code = 3'd1; cfg_need_code = 2'd1;
        cfg_bw_code = 2'd3; cfg_win_code = 3'd7;
        data_in = 1'b1;
        repeat (3) @(negedge clk);
        cfg_poll_en = 1'b1;
        @(negedge clk);
        check(rx_pwr_en === 1'b0, "R2 sleep entry", int'(rx_pwr_en), 0);
        slept = 1;
        for (int k = 0; k < 30; k++) begin
            data_in = ~data_in;
            @(negedge clk);
            slept++;
            check(data_out === 1'b0, "R3 data in sleep", int'(data_out), 0);
        end
        while (!rx_pwr_en && slept < 60000) begin
            slept++;
            @(negedge clk);
        end
        check((slept - (exp_sleep(1) + 1)) <= 2 && (slept - (exp_sleep(1) + 1)) >= -2,
              "R2 sleep code1", slept, exp_sleep(1) + 1);
        arm(0, 7, 1, 3, slept);
        check((slept - (exp_sleep(0) + 1)) <= 2 && (slept - (exp_sleep(0) + 1)) >= -2,
              "R2 sleep code0", slept, exp_sleep(0) + 1);

        // R4 boundary and R6: width equal to window (38) is bad
        repeat (4) toggle_hold(38);
        toggle_hold(6);
        check(rx_pwr_en === 1'b0, "R6 four bad to sleep", int'(rx_pwr_en), 0);
        wait_wake();
        repeat (4) toggle_hold(39);
        check(link_up === 1'b0, "R4 before last valid", int'(link_up), 0);
        toggle_hold(6);
        check(link_up === 1'b1, "R4 width window+1 valid", int'(link_up), 1);

        // R4 with another window: bw 1, code 3 -> 228
        arm(0, 3, 1, 1, slept);
        repeat (4) toggle_hold(228);
        toggle_hold(6);
        check(rx_pwr_en === 1'b0, "R4 228 is bad", int'(rx_pwr_en), 0);
        wait_wake();
        repeat (4) toggle_hold(229);
        toggle_hold(6);
        check(link_up === 1'b1, "R4 229 is valid", int'(link_up), 1);

        // R10: need code 0 locks on entry
        arm(0, 7, 0, 3, slept);
        repeat (2) @(negedge clk);
        check(link_up === 1'b1, "R10 zero need lock", int'(link_up), 1);

        // R7: bad run clears valid streak; R3 data quiet while polling
        arm(0, 7, 1, 3, slept);
        repeat (3) toggle_hold(60);
        toggle_hold(10);
        repeat (4) toggle_hold(60);
        check(link_up === 1'b0, "R7 streak cleared", int'(link_up), 0);
        check(data_out === 1'b0, "R3 data in poll", int'(data_out), 0);
        toggle_hold(6);
        check(link_up === 1'b1, "R7 fourth valid locks", int'(link_up), 1);

        // R8: valid run clears bad streak
        arm(0, 7, 1, 3, slept);
        repeat (3) toggle_hold(10);
        toggle_hold(60);
        repeat (3) toggle_hold(10);
        toggle_hold(6);
        check(rx_pwr_en === 1'b1 && link_up === 1'b0, "R8 still polling",
              int'(rx_pwr_en), 1);
        toggle_hold(6);
        check(rx_pwr_en === 1'b0, "R8 fourth bad sleeps", int'(rx_pwr_en), 0);

        // R11: idle time before first edge is not a measurement
        arm(0, 7, 1, 3, slept);
        repeat (4) toggle_hold(60);
        check(link_up === 1'b0, "R11 first edge only arms", int'(link_up), 0);
        toggle_hold(6);
        check(link_up === 1'b1, "R11 lock after four runs", int'(link_up), 1);

        // R12: saturation keeps an over-long run valid
        arm(0, 0, 1, 0, slept);
        toggle_hold(1500);
        repeat (3) toggle_hold(700);
        toggle_hold(6);
        check(link_up === 1'b1, "R12 saturated run valid", int'(link_up), 1);

        // R9: stays locked through a long idle, data released, restart on re-enable
        repeat (3000) @(negedge clk);
        check(link_up === 1'b1 && rx_pwr_en === 1'b1, "R9 lock holds",
              int'(link_up), 1);
        data_in = 1'b1;
        repeat (3) @(negedge clk);
        check(data_out === 1'b1, "R9 data released high", int'(data_out), 1);
        data_in = 1'b0;
        repeat (3) @(negedge clk);
        check(data_out === 1'b0, "R9 data released low", int'(data_out), 0);
        cfg_poll_en = 1'b0;
        repeat (2) @(negedge clk);
        check(link_up === 1'b0 && rx_pwr_en === 1'b1, "R1 enable dropped",
              int'(link_up), 0);
        cfg_poll_en = 1'b1;
        @(negedge clk);
        check(rx_pwr_en === 1'b0, "R9 re-enable sleeps", int'(rx_pwr_en), 0);

        // Random configurations (R5, R6, R4)
        for (int it = 0; it < 6; it++) begin
            int bw = 1 + int'($urandom % 3);
            int wc = int'($urandom % 8);
            int nc = 1 + int'($urandom % 3);
            int win = exp_window(wc, bw);
            arm(int'($urandom % 2), wc, nc, bw, slept);
            if (it % 2 == 1) begin
                for (int b = 0; b < 5; b++)
                    toggle_hold(3 + int'($urandom % (win - 5)));
                repeat (3) @(negedge clk);
                check(rx_pwr_en === 1'b0, "R6 random bad sleeps", int'(rx_pwr_en), 0);
                wait_wake();
            end
            for (int b = 0; b < exp_need(nc); b++)
                toggle_hold(win + 2 + int'($urandom % (win / 2 + 1)));
            check(link_up === 1'b0, "R5 one run short", int'(link_up), 0);
            toggle_hold(6);
            check(link_up === 1'b1, "R5 random lock", int'(link_up), 1);
        end

        finish_run();
    end

endmodule